// File: doc/BRIEF.md
# Timed Reply Serialiser

This block sits after a pulse-interval decoder in a contactless card emulation path. It watches each closed frame reported by the decoder. When a frame has no complete bytes and exactly seven loose bits, it treats the frame as the opening handshake from the reader and arms a reply. Every other frame shape is dropped without any reaction.

After it is armed, the block waits on the decoder's shared interval counter, which counts ticks since the reader's most recent rising edge. When that counter reaches the start threshold, the block drives a short constant reply onto one serial line, one raw bit per fixed period and with no line coding. Each bit period is measured by a counter inside the block that advances on the same tick enable as the decoder. Once the first bit is out, a restart of the decoder's counter has no effect on the reply timing. A busy flag covers the whole armed interval.

Top module: `response_tx`

## Requirements
- R1: A reply is armed only by a `frm_valid` strobe whose `frm_bytes` is 0 and whose `frm_bits` is 7. Strobes with any other pair leave `busy` low and `tx_out` low.
- R2: The reply is the low 6 bits of the constant 0x2B, least significant bit first, so the line carries 1, 1, 0, 1, 0, 1.
- R3: While armed and waiting, `tx_out` stays low. The first reply bit appears on `tx_out` at the first clock edge where `ivl_cnt` is 490 or more.
- R4: Each reply bit is held for exactly 150 clock edges at which `tick_en` is high, counted after the edge that started it. Edges with `tick_en` low do not shorten the bit.
- R5: At the edge that ends the sixth bit period, `tx_out` returns low and `busy` falls. `tx_out` is never high while `busy` is low.
- R6: `busy` rises at the edge that samples a matching frame strobe and stays high through the wait and all six bit periods.
- R7: A frame strobe that arrives while `busy` is high is ignored, and so is a change of `ivl_cnt` after the first bit has started. The waveform and the end time of the reply are unchanged.
- R8: An active-low `rst_n` forces `tx_out` and `busy` low at once and returns the block to idle. After release, a matching frame produces a complete reply again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick enable, shared with the decoder |
| frm_valid | input | 1 | One-cycle strobe: a received frame has closed |
| frm_bytes | input | BYTE_W (4) | Complete bytes in the closed frame |
| frm_bits | input | 3 | Residual bits in the closed frame |
| ivl_cnt | input | CNT_W (16) | Decoder tick count since the last reader rising edge |
| busy | output | 1 | High from arming until the last bit period ends |
| tx_out | output | 1 | Serial reply line, low when idle |

## Verification
The assertions take for granted that `frm_valid` lasts one cycle per closed frame and that `tick_en` is the only thing that moves the bit timing. They check bit stability only on edges where the enable is low. The stimulus keeps within this by pulsing the strobe for exactly one cycle, advancing its model of the interval counter only on ticks, and driving everything on the falling edge. Frames injected during a reply, together with a forced restart of the interval counter, show that the reply waveform keeps the same bit pattern and end time.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
   typedef enum logic [1:0] {
      RTX_IDLE = 2'd0,
      RTX_WAIT = 2'd1,
      RTX_SEND = 2'd2
   } rtx_state_e;
endpackage

// File: rtl/rtx_frame_match.sv
module rtx_frame_match #(
   parameter int unsigned BYTE_W     = 4,
   parameter int unsigned TRIG_BYTES = 0,
   parameter int unsigned TRIG_BITS  = 7
) (
   input  logic [BYTE_W-1:0] frm_bytes,
   input  logic [2:0]        frm_bits,
   output logic              hit
);
   localparam logic [BYTE_W-1:0] BYTES_C = BYTE_W'(TRIG_BYTES);
   localparam logic [2:0]        BITS_C  = 3'(TRIG_BITS);

   generate
      if (TRIG_BITS > 7) begin : g_bad_bits
         $error("TRIG_BITS must fit in three bits");
      end
      if (TRIG_BYTES >= (1 << BYTE_W)) begin : g_bad_bytes
         $error("TRIG_BYTES must fit in BYTE_W bits");
      end
   endgenerate

   assign hit = (frm_bytes == BYTES_C) && (frm_bits == BITS_C);
endmodule

// File: rtl/rtx_bit_timer.sv
module rtx_bit_timer #(
   parameter int unsigned PERIOD = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick_en,
   output logic bit_done
);
   localparam int unsigned      CW    = $clog2(PERIOD);
   localparam logic [CW-1:0]    LASTC = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("PERIOD must be at least 2 ticks");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign bit_done = run && tick_en && (cnt_q == LASTC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (run && tick_en)
         cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rtx_shifter.sv
module rtx_shifter #(
   parameter int unsigned     LEN       = 6,
   parameter logic [LEN-1:0]  PATTERN   = '0,
   parameter bit              LSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic shift,
   output logic dout,
   output logic last
);
   localparam int unsigned   IW    = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [IW-1:0] LASTI = IW'(LEN - 1);

   logic [LEN-1:0] sh_q;
   logic [IW-1:0]  idx_q;

   assign last = (idx_q == LASTI);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("LEN must be at least one bit");
      end
      if (LSB_FIRST) begin : g_lsb
         assign dout = sh_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh_q <= '0;
            else if (load)
               sh_q <= PATTERN;
            else if (shift)
               sh_q <= sh_q >> 1;
         end
      end else begin : g_msb
         assign dout = sh_q[LEN-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh_q <= '0;
            else if (load)
               sh_q <= PATTERN;
            else if (shift)
               sh_q <= sh_q << 1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= '0;
      else if (shift)
         idx_q <= idx_q + 1'b1;
   end
endmodule

// File: rtl/response_tx.sv
module response_tx #(
   parameter int unsigned          BYTE_W      = 4,
   parameter int unsigned          CNT_W       = 16,
   parameter int unsigned          START_TICKS = 490,
   parameter int unsigned          BIT_TICKS   = 150,
   parameter int unsigned          REPLY_LEN   = 6,
   parameter logic [7:0]           REPLY_WORD  = 8'h2B,
   parameter bit                   LSB_FIRST   = 1'b1,
   parameter int unsigned          TRIG_BYTES  = 0,
   parameter int unsigned          TRIG_BITS   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              frm_valid,
   input  logic [BYTE_W-1:0] frm_bytes,
   input  logic [2:0]        frm_bits,
   input  logic [CNT_W-1:0]  ivl_cnt,
   output logic              busy,
   output logic              tx_out
);
   import rtx_pkg::*;

   localparam logic [CNT_W-1:0]     START_C = CNT_W'(START_TICKS);
   localparam logic [REPLY_LEN-1:0] PAT_C   = REPLY_WORD[REPLY_LEN-1:0];

   generate
      if (REPLY_LEN > 8) begin : g_bad_len
         $error("REPLY_LEN cannot exceed the 8-bit reply word");
      end
      if (START_TICKS >= (1 << CNT_W)) begin : g_bad_start
         $error("START_TICKS must be reachable by ivl_cnt");
      end
   endgenerate

   rtx_state_e state_q, state_d;
   logic       hit, bit_done, last_bit, sh_dout;
   logic       arm, go;

   rtx_frame_match #(
      .BYTE_W    (BYTE_W),
      .TRIG_BYTES(TRIG_BYTES),
      .TRIG_BITS (TRIG_BITS)
   ) u_match (
      .frm_bytes(frm_bytes),
      .frm_bits (frm_bits),
      .hit      (hit)
   );

   assign arm = (state_q == RTX_IDLE) && frm_valid && hit;
   assign go  = (state_q == RTX_WAIT) && (ivl_cnt >= START_C);

   rtx_bit_timer #(
      .PERIOD(BIT_TICKS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q != RTX_SEND),
      .run     (state_q == RTX_SEND),
      .tick_en (tick_en),
      .bit_done(bit_done)
   );

   rtx_shifter #(
      .LEN      (REPLY_LEN),
      .PATTERN  (PAT_C),
      .LSB_FIRST(LSB_FIRST)
   ) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .load (arm),
      .shift(bit_done && !last_bit),
      .dout (sh_dout),
      .last (last_bit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RTX_IDLE: if (arm) state_d = RTX_WAIT;
         RTX_WAIT: if (go)  state_d = RTX_SEND;
         RTX_SEND: if (bit_done && last_bit) state_d = RTX_IDLE;
         default:  state_d = RTX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= RTX_IDLE;
      else
         state_q <= state_d;
   end

   assign busy   = (state_q != RTX_IDLE);
   assign tx_out = (state_q == RTX_SEND) && sh_dout;
endmodule

// File: rtl/rtx_checker.sv
module rtx_checker #(
   parameter int unsigned BYTE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              frm_valid,
   input logic [BYTE_W-1:0] frm_bytes,
   input logic [2:0]        frm_bits,
   input logic              busy,
   input logic              tx_out,
   input logic [1:0]        state_q
);
   // R1
   trig_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !busy && !((frm_bytes == '0) && (frm_bits == 3'd7))) |=> !busy);

   // R6
   arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(frm_valid && (frm_bytes == '0) && (frm_bits == 3'd7)));

   // R5
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_out);

   // R4
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 2'd2 && !tick_en) |=> (busy && $stable(tx_out)));

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!busy && !tx_out));
endmodule

bind response_tx rtx_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .frm_valid(frm_valid),
   .frm_bytes(frm_bytes),
   .frm_bits (frm_bits),
   .busy     (busy),
   .tx_out   (tx_out),
   .state_q  (state_q)
);

// File: tb/sim_response_tx.sv
`timescale 1ns/1ps
module sim_response_tx;
   localparam int          START = 490;
   localparam int          BITP  = 150;
   localparam int          NBITS = 6;
   localparam logic [5:0]  EXP_BITS = 6'b101011;  // 0x2B low six bits

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        frm_valid = 1'b0;
   logic [3:0]  frm_bytes = '0;
   logic [2:0]  frm_bits = '0;
   logic [15:0] ivl_cnt = '0;
   logic        busy, tx_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   response_tx u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .frm_valid(frm_valid),
      .frm_bytes(frm_bytes),
      .frm_bits (frm_bits),
      .ivl_cnt  (ivl_cnt),
      .busy     (busy),
      .tx_out   (tx_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // R8 reset state
   task automatic t_reset();
      @(negedge clk);
      chk("R8 busy in reset", busy, 0);
      chk("R8 tx in reset", tx_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 busy after release", busy, 0);
   endtask

   // R1 non-matching frames
   task automatic t_nomatch(input int nb, input int nbits);
      int bad = 0;
      frm_bytes = 4'(nb); frm_bits = 3'(nbits);
      frm_valid = 1'b1; ivl_cnt = 16'd480; tick_en = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (busy || tx_out) bad++;
         ivl_cnt = ivl_cnt + 1'b1;
         @(negedge clk);
      end
      chk($sformatf("R1 no arm bytes=%0d bits=%0d", nb, nbits), bad, 0);
   endtask

   // R2 R3 R4 R5 R6 R7: full reply; div=2 halves tick rate; inject adds a frame and counter restart mid-reply
   task automatic t_reply(input int div, input bit inject, input string tag);
      bit started = 0;
      bit injected = 0;
      bit prev_tick;
      int m = 0;
      int prev_ivl;
      frm_bytes = 4'd0; frm_bits = 3'd7;
      frm_valid = 1'b1; ivl_cnt = 16'd200; tick_en = 1'b1;
      prev_ivl = 200; prev_tick = 1'b1;
      @(negedge clk);
      chk({"R6 busy after arm ", tag}, busy, 1);
      chk({"R3 tx low after arm ", tag}, tx_out, 0);
      for (int cyc = 0; cyc < 6000; cyc++) begin
         // drive next inputs
         frm_valid = 1'b0;
         if (inject && started && !injected && m >= 300) begin
            frm_valid = 1'b1;
            ivl_cnt = '0;
            injected = 1'b1;
         end
         tick_en = (div == 1) ? 1'b1 : ~tick_en;
         if (tick_en) ivl_cnt = ivl_cnt + 1'b1;
         prev_ivl = int'(ivl_cnt);
         prev_tick = tick_en;
         @(negedge clk);
         if (!started) begin
            if (prev_ivl >= START) begin
               started = 1'b1;
               m = 0;
            end else begin
               if (busy != 1 || tx_out != 0)
                  chk({"R3 wait low ", tag}, {busy, tx_out}, 2);
               continue;
            end
         end else if (prev_tick) begin
            m++;
         end
         if (m < NBITS*BITP) begin
            if (m == 0 || (m % BITP) == 0 || (m % BITP) == BITP-1)
               chk($sformatf("R2 R4 bit %0d tick %0d %s", m/BITP, m, tag), tx_out, EXP_BITS[m/BITP]);
            else if (tx_out != EXP_BITS[m/BITP] || !busy)
               chk({"R4 R7 hold ", tag}, {busy, tx_out}, {1'b1, EXP_BITS[m/BITP]});
         end else begin
            chk({"R5 tx low at end ", tag}, tx_out, 0);
            chk({"R5 busy low at end ", tag}, busy, 0);
            break;
         end
      end
      chk({"R5 reply completed ", tag}, int'(started && m == NBITS*BITP), 1);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (busy || tx_out) chk({"R7 no retrigger ", tag}, {busy, tx_out}, 0);
      end
      chk({"R7 idle after reply ", tag}, busy, 0);
   endtask

   // R8 reset during a reply
   task automatic t_midreset();
      frm_bytes = 4'd0; frm_bits = 3'd7;
      frm_valid = 1'b1; ivl_cnt = 16'd490; tick_en = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
      repeat (200) @(negedge clk);
      chk("R8 sending before reset", busy, 1);
      rst_n = 1'b0;
      #1;
      chk("R8 busy forced low", busy, 0);
      chk("R8 tx forced low", tx_out, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R8 idle after release", busy, 0);
   endtask

   initial begin
      t_reset();
      t_nomatch(0, 6);
      t_nomatch(1, 7);
      t_nomatch(0, 0);
      t_nomatch(2, 3);
      t_reply(1, 1'b0, "base");
      t_reply(2, 1'b0, "half-rate");
      t_reply(1, 1'b1, "inject");
      t_midreset();
      t_reply(1, 1'b0, "R8 recovery");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule